// File: doc/BRIEF.md
# Dual-Mode Saturating Link Error Counter Register

This block is a 16-bit status register that tallies receive-side trouble on a link and is read over a simple register bus. A mode input decides what the register counts. With mode low, the upper byte counts how often the local receiver has dropped into a not-OK condition, and the lower byte counts how often the remote receiver has been seen as not-OK. With mode high, all sixteen bits form one counter of CRC errors.

Every counter stops at its all-ones value rather than wrapping, and a read returns the value and clears the counters for the next interval. A change of mode wipes the register, so a value gathered in one mode is never read back under the other mode's layout. Not-OK conditions are level inputs and are counted once per entry into the bad state. The CRC error input is a per-error strobe.

Top module: `errcnt_reg`

## Requirements
- R1: With mode at 0, rd_data[15:8] holds the number of rising edges of local_nok since the last read.
- R2: With mode at 0, rd_data[7:0] holds the number of rising edges of remote_nok since the last read.
- R3: In mode 0 each 8-bit field stops at 8'hFF and does not wrap to zero.
- R4: With mode at 1, rd_data[15:0] holds the number of clock cycles in which crc_err was high since the last read.
- R5: In mode 1 the 16-bit count stops at 16'hFFFF and does not wrap.
- R6: A cycle with rd_stb high and no event returns the current count on rd_data in that cycle and leaves the count at zero after the next clock edge.
- R7: After reset rd_data reads 16'h0000.
- R8: A not-OK input held high for many cycles adds exactly one to its field.
- R9: If a counted event and rd_stb fall in the same cycle, rd_data shows the count before that event and the count after the edge is 1.
- R10: A change of the mode input clears all counters at the next clock edge; events in the cycle of the change are dropped, and a read after the change returns 0.
- R11: In mode 1 local_nok and remote_nok have no effect; in mode 0 crc_err has no effect.
- R12: rd_data always shows the live count of the current mode combinationally; a read takes effect only at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_crc | input | 1 | 0: two not-OK byte counters, 1: one 16-bit CRC error counter |
| local_nok | input | 1 | Level, high while the local receiver is not OK |
| remote_nok | input | 1 | Level, high while the remote receiver is seen as not OK |
| crc_err | input | 1 | One cycle high per CRC error |
| rd_stb | input | 1 | Single-cycle read strobe; clears the counters at the next edge |
| rd_data | output | 16 | Register contents for the current mode |

## Verification
The read-clear and the increment can land in the same cycle, and so can the mode change and an event. The bench forces both on purpose: a read is issued on the exact cycle of a local edge or a CRC strobe, and a mode flip is issued while events are active, with a random phase adding many more such collisions. Each case is judged by a bench model that returns the pre-event value on the read cycle, then expects 1 after a read collision and 0 after a mode flip.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

  typedef enum logic {
    CNT_MODE_LINK = 1'b0,
    CNT_MODE_CRC  = 1'b1
  } cnt_mode_e;

  // Entry into a level condition: high now, low one cycle earlier.
  function automatic logic entered(input logic now_lvl, input logic last_lvl);
    return now_lvl & ~last_lvl;
  endfunction

endpackage

// File: rtl/rise_det.sv
module rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  import errcnt_pkg::*;

  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = entered(lvl[i], lvl_q[i]);

    // R8: a level held high yields one event, never two in a row
    a_r8_one_per_entry: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end

endmodule

// File: rtl/sat_ctr.sv
module sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zap,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  // Priority: mode flip wipes, read restarts (keeping a same-cycle event),
  // otherwise a saturating step.
  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
                                            input logic z, input logic c,
                                            input logic i);
    if (z)                  return '0;
    if (c)                  return i ? ONE : '0;
    if (i && cur != MAXV)   return cur + ONE;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_val(cnt, zap, clr, inc);
  end

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr && !zap) |=> cnt == MAXV);

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !zap && cnt != MAXV) |=> cnt == $past(cnt) + ONE);

  a_r6_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc && !zap) |=> cnt == '0);

  a_r9_read_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc && !zap) |=> cnt == ONE);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc && !zap) |=> $stable(cnt));

endmodule

// File: rtl/errcnt_reg.sv
module errcnt_reg #(
  parameter int NARROW_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_crc,
  input  logic                  local_nok,
  input  logic                  remote_nok,
  input  logic                  crc_err,
  input  logic                  rd_stb,
  output logic [2*NARROW_W-1:0] rd_data
);
  import errcnt_pkg::*;

  localparam int WIDE_W = 2 * NARROW_W;

  cnt_mode_e cur_mode;
  logic      mode_q;
  logic      mode_flip;
  logic      link_mode, crc_mode;
  logic [1:0] nok_rise;
  logic      loc_inc, rem_inc, crc_inc;
  logic      link_clr, crc_clr;
  logic [NARROW_W-1:0] loc_cnt, rem_cnt;
  logic [WIDE_W-1:0]   crc_cnt;

  assign cur_mode  = cnt_mode_e'(mode_crc);
  assign link_mode = (cur_mode == CNT_MODE_LINK);
  assign crc_mode  = (cur_mode == CNT_MODE_CRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_crc;
  end
  assign mode_flip = (mode_q != mode_crc);

  rise_det #(.N(2)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({local_nok, remote_nok}),
    .rise  (nok_rise)
  );

  assign loc_inc  = link_mode & nok_rise[1];
  assign rem_inc  = link_mode & nok_rise[0];
  assign crc_inc  = crc_mode & crc_err;
  assign link_clr = link_mode & rd_stb;
  assign crc_clr  = crc_mode & rd_stb;

  sat_ctr #(.W(NARROW_W)) u_loc (
    .clk(clk), .rst_n(rst_n), .zap(mode_flip), .clr(link_clr),
    .inc(loc_inc), .cnt(loc_cnt)
  );

  sat_ctr #(.W(NARROW_W)) u_rem (
    .clk(clk), .rst_n(rst_n), .zap(mode_flip), .clr(link_clr),
    .inc(rem_inc), .cnt(rem_cnt)
  );

  sat_ctr #(.W(WIDE_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .zap(mode_flip), .clr(crc_clr),
    .inc(crc_inc), .cnt(crc_cnt)
  );

  assign rd_data = crc_mode ? crc_cnt : {loc_cnt, rem_cnt};

  a_r10_flip_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> rd_data == '0);

  a_r11_link_idle_in_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_mode && !mode_flip) |=> (loc_cnt == '0 && rem_cnt == '0));

  a_r11_crc_idle_in_link: assert property (@(posedge clk) disable iff (!rst_n)
    (link_mode && !mode_flip) |=> crc_cnt == '0);

  a_r6_crc_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && crc_mode && !crc_err && !mode_flip) |=> rd_data == '0);

endmodule

// File: tb/tb_errcnt_reg.sv
`timescale 1ns/1ps
module tb_errcnt_reg;

  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_crc = 1'b0, local_nok = 1'b0, remote_nok = 1'b0;
  logic crc_err = 1'b0, rd_stb = 1'b0;
  logic [2*NW-1:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // bench model
  int  m_loc, m_rem, m_crc;
  bit  m_mode, m_pl, m_pr;
  logic [15:0] last_obs;

  always #2.5 clk = ~clk;

  errcnt_reg #(.NARROW_W(NW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_crc(mode_crc), .local_nok(local_nok),
    .remote_nok(remote_nok), .crc_err(crc_err), .rd_stb(rd_stb),
    .rd_data(rd_data)
  );

  function automatic int bump(int v, bit ev, bit rd, int top);
    int s;
    s = v + (ev ? 1 : 0);
    if (s > top) s = top;
    return rd ? (ev ? 1 : 0) : s;
  endfunction

  function automatic logic [15:0] view(bit m);
    return m ? 16'(m_crc) : {8'(m_loc), 8'(m_rem)};
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit m, input bit l, input bit r, input bit c,
                      input bit rd, input string tag);
    bit flip, el, er;
    @(negedge clk);
    mode_crc = m; local_nok = l; remote_nok = r; crc_err = c; rd_stb = rd;
    #1;
    last_obs = rd_data;
    check(rd_data, view(m), tag);
    @(posedge clk);
    flip = (m != m_mode);
    el = l & ~m_pl;
    er = r & ~m_pr;
    if (flip) begin
      m_loc = 0; m_rem = 0; m_crc = 0;
    end else if (!m) begin
      m_loc = bump(m_loc, el, rd, 255);
      m_rem = bump(m_rem, er, rd, 255);
    end else begin
      m_crc = bump(m_crc, c, rd, 65535);
    end
    m_mode = m; m_pl = l; m_pr = r;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    m_loc = 0; m_rem = 0; m_crc = 0; m_mode = 0; m_pl = 0; m_pr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rd_data, 16'h0000, "R7 reset value");

    // R1: three local entries
    for (int i = 0; i < 3; i++) begin
      tick(0, 1, 0, 0, 0, "R1");
      tick(0, 0, 0, 0, 0, "R1");
    end
    tick(0, 0, 0, 0, 1, "R1");
    check(last_obs, 16'h0300, "R1 local count");

    // R8: long level counts once
    for (int i = 0; i < 12; i++) tick(0, 1, 0, 0, 0, "R8");
    tick(0, 0, 0, 0, 1, "R8");
    check(last_obs, 16'h0100, "R8 held level");

    // R2: remote entries alongside local ones
    for (int i = 0; i < 4; i++) begin
      tick(0, i < 2, 1, 0, 0, "R2");
      tick(0, 0, 0, 0, 0, "R2");
    end
    tick(0, 0, 0, 0, 1, "R2");
    check(last_obs, 16'h0204, "R2 remote count");

    // R3: byte saturation, then R6 clear
    for (int i = 0; i < 300; i++) begin
      tick(0, 1, 1, 0, 0, "R3");
      tick(0, 0, 0, 0, 0, "R3");
    end
    tick(0, 0, 0, 0, 1, "R3");
    check(last_obs, 16'hFFFF, "R3 byte saturation");
    tick(0, 0, 0, 0, 1, "R6");
    check(last_obs, 16'h0000, "R6 cleared by read");

    // R9 in mode 0: read on the cycle of a local entry
    tick(0, 1, 0, 0, 0, "R9");
    tick(0, 0, 0, 0, 0, "R9");
    tick(0, 1, 0, 0, 1, "R9");
    check(last_obs, 16'h0100, "R9 pre-event value");
    tick(0, 0, 0, 0, 1, "R9");
    check(last_obs, 16'h0100, "R9 event kept");

    // R4: CRC mode
    tick(1, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 5; i++) tick(1, 0, 0, 1, 0, "R4");
    tick(1, 0, 0, 0, 1, "R4");
    check(last_obs, 16'h0005, "R4 crc count");

    // R9 in mode 1
    tick(1, 0, 0, 1, 0, "R9");
    tick(1, 0, 0, 1, 0, "R9");
    tick(1, 0, 0, 1, 1, "R9");
    check(last_obs, 16'h0002, "R9 crc pre-event");
    tick(1, 0, 0, 0, 1, "R9");
    check(last_obs, 16'h0001, "R9 crc kept");

    // R5: 16-bit saturation
    for (int i = 0; i < 70000; i++) tick(1, 0, 0, 1, 0, "R5");
    tick(1, 0, 0, 0, 1, "R5");
    check(last_obs, 16'hFFFF, "R5 word saturation");
    tick(1, 0, 0, 0, 1, "R6");
    check(last_obs, 16'h0000, "R6 crc cleared");

    // R10: flips clear, events at the flip are dropped
    for (int i = 0; i < 7; i++) tick(1, 0, 0, 1, 0, "R10");
    tick(0, 1, 0, 1, 0, "R10");
    check(last_obs, 16'h0000, "R10 flip cycle");
    tick(0, 0, 0, 0, 0, "R10");
    check(last_obs, 16'h0000, "R10 flip dropped event");
    tick(0, 1, 1, 0, 0, "R10");
    tick(0, 0, 0, 0, 0, "R10");
    tick(1, 0, 0, 0, 0, "R10");
    tick(1, 0, 0, 0, 1, "R10");
    check(last_obs, 16'h0000, "R10 old link count gone");

    // R11: foreign events ignored
    for (int i = 0; i < 6; i++) begin
      tick(1, 1, 1, 0, 0, "R11");
      tick(1, 0, 0, 0, 0, "R11");
    end
    tick(1, 0, 0, 0, 1, "R11");
    check(last_obs, 16'h0000, "R11 nok ignored in crc mode");
    tick(0, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 1, 0, "R11");
    tick(0, 0, 0, 0, 1, "R11");
    check(last_obs, 16'h0000, "R11 crc ignored in link mode");

    // R12: random mix with a fixed seed
    begin
      bit m;
      int seed;
      seed = 7;
      m = 0;
      void'($urandom(seed));
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(199) == 0) m = ~m;
        tick(m, $urandom_range(2) == 0, $urandom_range(3) == 0,
             $urandom_range(1) == 0, $urandom_range(7) == 0, "R12");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule